// File: doc/BRIEF.md
# Data Processing ALU

A combinational 32-bit unit that computes the destination value of a three-address data-processing operation. It takes an operation code, a first operand read from a register, and a second operand. The second operand is either a second register value or an 8-bit signed immediate, sign-extended to the full word. The unit returns the word result and a single carry bit. The carry is produced only by the add and subtract operations.

Eight operations are supported: two moves (plain and inverted), add, subtract, and four bitwise operations (AND, OR, exclusive OR and bit clear). Decode, the register file, shifts, multiply and divide sit outside this block. The result is meant to be written straight into the destination register by the surrounding datapath.

Top module: `alu_dp_core`

## Requirements
- R1: `op_i` selects the operation with this 3-bit encoding: 0 move, 1 move-inverted, 2 add, 3 subtract, 4 AND, 5 OR, 6 exclusive OR, 7 bit clear.
- R2: When `use_imm_i` is 1, the second operand is `imm_i` read as a signed value (-128..127) and sign-extended to 32 bits. For example, 0x80 becomes 0xFFFFFF80 and 0x7F becomes 0x0000007F.
- R3: Move returns the second operand unchanged, whatever the value of `opa_i`.
- R4: Move-inverted returns the one's complement of the second operand. For example, immediate 0x20 gives 0xFFFFFFDF.
- R5: Add returns `opa_i` plus the second operand, modulo 2^32. `carry_o` is the carry out of bit 31.
- R6: Subtract returns `opa_i` minus the second operand, modulo 2^32. `carry_o` is 1 when no borrow occurs, which is when `opa_i` >= the second operand, taken as unsigned.
- R7: AND, OR and exclusive OR act bit by bit over all 32 bits. For example, 0x42 OR 0x20 gives 0x62.
- R8: Bit clear returns `opa_i` AND the complement of the second operand. For example, 0x63 with mask 0x20 gives 0x43.
- R9: `carry_o` is 0 for every operation other than add and subtract.
- R10: When `use_imm_i` is 0, `imm_i` has no effect on the outputs. When it is 1, `opb_reg_i` has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 3 | Operation code |
| opa_i | input | 32 | First operand (register) |
| opb_reg_i | input | 32 | Second operand, register form |
| imm_i | input | 8 | Second operand, signed immediate form |
| use_imm_i | input | 1 | 1 selects the immediate as second operand |
| result_o | output | 32 | Destination value |
| carry_o | output | 1 | Adder carry out, or no-borrow for subtract; 0 otherwise |

## Verification
Directed operands cover the following cases:
- Carry wrap at all-ones plus one.
- Subtract with equal operands, and subtract that borrows.
- Immediates at the sign boundary (0x7F, 0x80, 0xFF).
- The worked character-case masks.

Together these separate a correct carry and no-borrow sense from an inverted or dropped one, and sign extension from zero extension. Random operands for every operation, on both operand paths, catch a swapped opcode or a wrong bitwise function, since each of these disagrees with the reference on almost any data. Held-output checks, in which the unused operand source or `opa_i` is toggled on its own, confirm that the operand path ignores its deselected input.

// File: rtl/alu_dp_pkg.sv
package alu_dp_pkg;
  typedef enum logic [2:0] {
    OP_MOV = 3'd0,
    OP_MVN = 3'd1,
    OP_ADD = 3'd2,
    OP_SUB = 3'd3,
    OP_AND = 3'd4,
    OP_ORR = 3'd5,
    OP_EOR = 3'd6,
    OP_BIC = 3'd7
  } alu_op_e;

  // low two bits of a bitwise op pick the function in the logic unit
  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_ORR = 2'd1,
    LG_EOR = 2'd2,
    LG_BIC = 2'd3
  } logic_fn_e;
endpackage

// File: rtl/alu_opb_sel.sv
module alu_opb_sel #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8
) (
  input  logic [DATA_W-1:0] reg_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              use_imm_i,
  output logic [DATA_W-1:0] opb_o
);
  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_ext;

  assign imm_ext = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
  assign opb_o   = use_imm_i ? imm_ext : reg_i;
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              cout_o
);
  localparam int SUM_W = DATA_W + 1;

  logic [DATA_W-1:0] b_eff;
  logic [SUM_W-1:0]  full;

  // subtract as a + ~b + 1; carry out then means no borrow
  assign b_eff  = sub_i ? ~b_i : b_i;
  assign full   = {1'b0, a_i} + {1'b0, b_eff} + SUM_W'(sub_i);
  assign sum_o  = full[DATA_W-1:0];
  assign cout_o = full[DATA_W];
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_dp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic_fn_e         fn_i,
  output logic [DATA_W-1:0] y_o
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    always_comb begin
      unique case (fn_i)
        LG_AND:  y_o[i] = a_i[i] & b_i[i];
        LG_ORR:  y_o[i] = a_i[i] | b_i[i];
        LG_EOR:  y_o[i] = a_i[i] ^ b_i[i];
        LG_BIC:  y_o[i] = a_i[i] & ~b_i[i];
        default: y_o[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/alu_dp_core.sv
module alu_dp_core
  import alu_dp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8
) (
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_reg_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              use_imm_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o
);
  alu_op_e           op;
  logic [DATA_W-1:0] opb;
  logic [DATA_W-1:0] sum;
  logic              cout;
  logic [DATA_W-1:0] lg_y;
  logic              is_arith;

  assign op       = alu_op_e'(op_i);
  assign is_arith = (op == OP_ADD) || (op == OP_SUB);

  alu_opb_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opb (
    .reg_i    (opb_reg_i),
    .imm_i    (imm_i),
    .use_imm_i(use_imm_i),
    .opb_o    (opb)
  );

  alu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a_i   (opa_i),
    .b_i   (opb),
    .sub_i (op == OP_SUB),
    .sum_o (sum),
    .cout_o(cout)
  );

  alu_logic #(.DATA_W(DATA_W)) u_logic (
    .a_i (opa_i),
    .b_i (opb),
    .fn_i(logic_fn_e'(op_i[1:0])),
    .y_o (lg_y)
  );

  always_comb begin
    unique case (op)
      OP_MOV:  result_o = opb;
      OP_MVN:  result_o = ~opb;
      OP_ADD,
      OP_SUB:  result_o = sum;
      default: result_o = lg_y;
    endcase
  end

  assign carry_o = is_arith & cout;
endmodule

// File: rtl/alu_dp_core_chk.sv
module alu_dp_core_chk #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8
) (
  input logic [2:0]        op_i,
  input logic [DATA_W-1:0] opa_i,
  input logic [DATA_W-1:0] opb_reg_i,
  input logic [IMM_W-1:0]  imm_i,
  input logic              use_imm_i,
  input logic [DATA_W-1:0] opb,
  input logic [DATA_W-1:0] result_o,
  input logic              carry_o
);
  localparam int SUM_W = DATA_W + 1;

  logic known;
  assign known = !$isunknown({op_i, opa_i, opb_reg_i, imm_i, use_imm_i});

  always_comb begin
    if (known) begin
      if (use_imm_i) begin
        a_r2_imm_sign_ext: assert (opb == DATA_W'($signed(imm_i)));
      end else begin
        a_r10_reg_path: assert (opb == opb_reg_i);
      end
      case (op_i)
        3'd0: begin a_r3_mov_passes: assert (result_o == opb); end
        3'd1: begin a_r4_mvn_inverts: assert ((result_o ^ opb) == '1); end
        3'd2: begin
          a_r5_add_sum: assert ({carry_o, result_o} == (SUM_W'(opa_i) + SUM_W'(opb)));
        end
        3'd3: begin
          a_r6_sub_diff: assert (((result_o + opb) == opa_i) && (carry_o == (opa_i >= opb)));
        end
        3'd4: begin a_r7_and_bits: assert ((result_o | ~(opa_i & opb)) == '1 && (result_o & ~opa_i) == '0); end
        3'd7: begin a_r8_bic_clears: assert ((result_o & opb) == '0 && (result_o | opb) == (opa_i | opb)); end
        default: ;
      endcase
      if (op_i != 3'd2 && op_i != 3'd3) begin
        a_r9_carry_quiet: assert (!carry_o);
      end
    end
  end
endmodule

bind alu_dp_core alu_dp_core_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
  .op_i     (op_i),
  .opa_i    (opa_i),
  .opb_reg_i(opb_reg_i),
  .imm_i    (imm_i),
  .use_imm_i(use_imm_i),
  .opb      (opb),
  .result_o (result_o),
  .carry_o  (carry_o)
);

// File: tb/alu_dp_core_tb_top.sv
module alu_dp_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  op_i = '0;
  logic [31:0] opa_i = '0;
  logic [31:0] opb_reg_i = '0;
  logic [7:0]  imm_i = '0;
  logic        use_imm_i = 1'b0;
  logic [31:0] result_o;
  logic        carry_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  alu_dp_core dut_i (
    .op_i     (op_i),
    .opa_i    (opa_i),
    .opb_reg_i(opb_reg_i),
    .imm_i    (imm_i),
    .use_imm_i(use_imm_i),
    .result_o (result_o),
    .carry_o  (carry_o)
  );

  function automatic void model(input int op, input logic [31:0] a, input logic [31:0] b,
                                output logic [31:0] r, output logic c);
    longint unsigned s;
    c = 1'b0;
    case (op)
      0: r = b;
      1: r = ~b;
      2: begin s = longint'(a) + longint'(b); r = s[31:0]; c = s[32]; end
      3: begin r = a - b; c = (a >= b); end
      4: r = a & b;
      5: r = a | b;
      6: r = a ^ b;
      default: r = a & ~b;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] er, input logic ec);
    checks++;
    if (result_o !== er || carry_o !== ec) begin
      errors++;
      $display("FAIL %s: got result=%08h carry=%0b, expected result=%08h carry=%0b",
               req, result_o, carry_o, er, ec);
    end
  endtask

  task automatic apply(input int op, input logic [31:0] a, input logic [31:0] rb,
                       input logic [7:0] imm, input logic ui);
    @(negedge clk);
    op_i = 3'(op); opa_i = a; opb_reg_i = rb; imm_i = imm; use_imm_i = ui;
    #1;
  endtask

  task automatic run(input string req, input int op, input logic [31:0] a,
                     input logic [31:0] rb, input logic [7:0] imm, input logic ui);
    logic [31:0] b, er;
    logic ec;
    b = ui ? 32'(int'($signed(imm))) : rb;
    model(op, a, b, er, ec);
    apply(op, a, rb, imm, ui);
    chk(req, er, ec);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // zero inputs: MOV of zero register
    apply(0, 0, 0, 0, 0);
    chk("R3 reset-state", 32'h0, 1'b0);

    run("R7 orr 0x42|0x20", 5, 32'h42, 32'h20, 8'h00, 0);
    chk("R7 orr literal", 32'h62, 1'b0);
    run("R8 bic 0x63", 7, 32'h63, 32'h20, 8'h00, 0);
    chk("R8 bic literal", 32'h43, 1'b0);
    run("R4 mvn imm", 1, 32'h1234, 32'h0, 8'h20, 1);
    chk("R4 mvn literal", 32'hFFFFFFDF, 1'b0);
    run("R2 imm 0x80", 0, 32'h0, 32'h0, 8'h80, 1);
    chk("R2 imm 0x80 literal", 32'hFFFFFF80, 1'b0);
    run("R2 imm 0x7F", 0, 32'h0, 32'h0, 8'h7F, 1);
    chk("R2 imm 0x7F literal", 32'h0000007F, 1'b0);
    run("R5 add wrap", 2, 32'hFFFFFFFF, 32'h0, 8'h01, 1);
    chk("R5 add wrap literal", 32'h0, 1'b1);
    run("R6 sub equal", 3, 32'h5, 32'h5, 8'h0, 0);
    chk("R6 sub equal literal", 32'h0, 1'b1);
    run("R6 sub borrow", 3, 32'h0, 32'h1, 8'h0, 0);
    chk("R6 sub borrow literal", 32'hFFFFFFFF, 1'b0);
    run("R6 sub imm -1", 3, 32'h10, 32'h0, 8'hFF, 1);
    run("R9 eor carry", 6, 32'hFFFFFFFF, 32'hFFFFFFFF, 8'h0, 0);

    // R10: deselected source toggled, output must hold
    apply(2, 32'h100, 32'h23, 8'h00, 0);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); imm_i = 8'($urandom); #1;
      chk("R10 imm ignored", 32'h123, 1'b0);
    end
    apply(5, 32'h100, 32'h0, 8'h0F, 1);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); opb_reg_i = $urandom; #1;
      chk("R10 reg ignored", 32'h10F, 1'b0);
    end
    // R3: MOV ignores opa_i
    apply(0, 32'h0, 32'hCAFE0001, 8'h0, 0);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); opa_i = $urandom; #1;
      chk("R3 mov ignores opa", 32'hCAFE0001, 1'b0);
    end

    // R1 encoding: random operands on every op, both paths
    for (int op = 0; op < 8; op++) begin
      for (int k = 0; k < 300; k++) begin
        run($sformatf("R1 op%0d random", op), op, $urandom, $urandom, 8'($urandom), 1'($urandom));
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule